// File: doc/BRIEF.md
# General-Purpose Timer with Capture

This block is a 16-bit up-counter for timing and event measurement. Its clock comes from one of three sources: the bus clock, the bus clock divided by sixteen, or falling edges on an external input pin. An 8-bit prescaler then slows that clock. When the counter reaches a programmed reference value, the block flags an event and drives an output pin. The output either gives a one-clock active-low pulse or changes state. After the reference, the counter either restarts from zero or keeps counting.

The same input pin can also serve as a capture trigger. A selected edge copies the current count into a capture register and raises a flag. Both flags live in an event register, and software clears them by writing ones. An interrupt request combines each flag with its enable.

Software sees the block through a small word-wide register port with a combinational read. Clearing the enable bit holds every piece of the timing state at its idle value. The mode and reference registers can still be written while the block is held.

Top module: `gp_timer`

## Requirements
- R1: Mode bits [15:8] hold a prescale value N, and the counter advances once per N+1 pulses of the selected source. N=0 gives no division and N=255 divides by 256.
- R2: Mode bits [2:1] pick the count source:
  - 00: stopped.
  - 01: every bus clock.
  - 10: one pulse per 16 bus clocks.
  - 11: each falling edge of `tmr_in`, taken after a two-flop synchronizer.
- R3: Mode bit [3] controls what happens after the reference value:
  - 1 (restart): the tick that follows the one on which the counter reached the reference value returns the counter to 0.
  - 0 (free-run): the counter keeps incrementing past the reference and wraps from all-ones to 0.
- R4: Mode bit [4] sets the output mode. `tmr_out` idles high.
  - 0 (pulse): `tmr_out` goes low for exactly one bus clock each time the counter reaches the reference value.
  - 1 (toggle): `tmr_out` inverts on each such arrival.
- R5: Mode bits [7:6] select the capture edge: 00 off, 01 rising, 10 falling, 11 both. A selected edge on the synchronized `tmr_in` copies the counter into the capture register and sets event bit 0. With 00, no edge changes the capture register or the flag.
- R6: Mode bit [5] enables the reference interrupt. `irq` is high while (event bit 1 AND bit [5]) OR (event bit 0 AND capture field non-zero) is true. Bit [5] has no effect on the capture term.
- R7: The event register holds bit 0 for capture and bit 1 for reference. Each bit is set by its event and cleared only by a write with a one in that bit position. A write with a zero in a bit position leaves that flag alone.
- R8: While mode bit [0] is 0, the following are held at their idle values: counter, prescaler, divide-by-16 stage, output (high), flags and capture register. The mode and reference registers remain writable and readable.
- R9: Register map by `reg_addr`: 0 mode, 1 reference, 2 capture (read-only), 3 counter (read-only), 4 event. After reset every register reads 0, `tmr_out` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| tmr_in | input | 1 | External clock / capture pin |
| tmr_out | output | 1 | Reference output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter, two synchronizer stages and a slow divider of 16. These values keep the full prescale range in reach within a few hundred cycles, including divide-by-256. Divider and prescaler compose for the slow source, which is checked against a bench formula. A restart reference as small as three makes many reference arrivals fit in a short window. That window lets the bench count pulse widths and toggle parity exactly.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int PRE_W = 8;
  localparam int REG_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;

  typedef enum logic [1:0] {
    SRC_STOP = 2'b00,
    SRC_BUS  = 2'b01,
    SRC_SLOW = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    cap_e             cap;
    logic             ref_ie;
    logic             toggle;
    logic             restart;
    src_e             src;
    logic             enable;
  } mode_t;

  // next value of a counter that returns to zero after reaching lim
  function automatic logic [PRE_W-1:0] f_pre_next(input logic [PRE_W-1:0] cur,
                                                   input logic [PRE_W-1:0] lim);
    return (cur == lim) ? '0 : cur + PRE_W'(1);
  endfunction

  // capture edge qualifier
  function automatic logic f_cap_hit(input cap_e sel, input logic rise, input logic fall);
    case (sel)
      CAP_RISE: return rise;
      CAP_FALL: return fall;
      CAP_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpt_pin_sync.sv
module gpt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];

  assign rise = sync_q[LAST] & ~prev_q;
  assign fall = ~sync_q[LAST] & prev_q;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rise && fall)); // R5
endmodule

// File: rtl/gpt_clk_gen.sv
module gpt_clk_gen
  import gpt_pkg::*;
#(
  parameter int DIV_SLOW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  src_e             src,
  input  logic             pin_fall,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  localparam int DIV_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_SLOW - 1);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic             src_pulse;

  always_comb begin
    case (src)
      SRC_BUS:  src_pulse = 1'b1;
      SRC_SLOW: src_pulse = (div_q == DIV_LAST);
      SRC_PIN:  src_pulse = pin_fall;
      default:  src_pulse = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else          div_q <= (div_q == DIV_LAST) ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (clr)       pre_q <= '0;
    else if (src_pulse) pre_q <= f_pre_next(pre_q, prescale);
  end

  assign tick = src_pulse && (pre_q == prescale);

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !src_pulse) |=> $stable(pre_q)); // R1
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_STOP) |-> !tick); // R2
endmodule

// File: rtl/gpt_core.sv
module gpt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             restart,
  input  logic             toggle,
  output logic [CNT_W-1:0] cnt,
  output logic             ref_hit,
  output logic             out_pin
);
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = (restart && cnt == ref_val) ? '0 : cnt + CNT_W'(1);
  assign ref_hit  = tick && (cnt_next == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_pin <= 1'b1;
    else if (clr)    out_pin <= 1'b1;
    else if (toggle) out_pin <= out_pin ^ ref_hit;
    else             out_pin <= ~ref_hit;
  end

  AST_PULSE_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle && !out_pin && $stable(toggle) && $stable(ref_val)) |-> (cnt == ref_val)); // R4
  AST_HOLD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && out_pin)); // R8
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt)); // R1
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_SLOW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tmr_in,
  output logic              tmr_out,
  output logic              irq
);
  mode_t            mode_q;
  logic [CNT_W-1:0] ref_q;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cnt;
  logic             cap_flag, ref_flag;
  logic             clr, tick, ref_hit, cap_evt;
  logic             pin_rise, pin_fall;
  logic             wr_mode, wr_ref, wr_evt;

  assign clr     = ~mode_q.enable;
  assign wr_mode = reg_we && reg_addr == A_MODE;
  assign wr_ref  = reg_we && reg_addr == A_REF;
  assign wr_evt  = reg_we && reg_addr == A_EVT;

  gpt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(tmr_in), .rise(pin_rise), .fall(pin_fall)
  );

  gpt_clk_gen #(.DIV_SLOW(DIV_SLOW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .clr(clr), .src(mode_q.src), .pin_fall(pin_fall),
    .prescale(mode_q.pre), .tick(tick)
  );

  gpt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .ref_val(ref_q),
    .restart(mode_q.restart), .toggle(mode_q.toggle), .cnt(cnt),
    .ref_hit(ref_hit), .out_pin(tmr_out)
  );

  assign cap_evt = mode_q.enable && f_cap_hit(mode_q.cap, pin_rise, pin_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(reg_wdata);
      if (wr_ref)  ref_q  <= CNT_W'(reg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (clr)     cap_q <= '0;
    else if (cap_evt) cap_q <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_flag <= 1'b0;
      ref_flag <= 1'b0;
    end else if (clr) begin
      cap_flag <= 1'b0;
      ref_flag <= 1'b0;
    end else begin
      if (cap_evt)                   cap_flag <= 1'b1;
      else if (wr_evt && reg_wdata[0]) cap_flag <= 1'b0;
      if (ref_hit)                   ref_flag <= 1'b1;
      else if (wr_evt && reg_wdata[1]) ref_flag <= 1'b0;
    end
  end

  assign irq = (ref_flag & mode_q.ref_ie) | (cap_flag & (mode_q.cap != CAP_OFF));

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = REG_W'(mode_q);
      A_REF:   reg_rdata = REG_W'(ref_q);
      A_CAP:   reg_rdata = REG_W'(cap_q);
      A_CNT:   reg_rdata = REG_W'(cnt);
      A_EVT:   reg_rdata = {{(REG_W-2){1'b0}}, ref_flag, cap_flag};
      default: reg_rdata = '0;
    endcase
  end

  AST_CAP_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.cap == CAP_OFF && !cap_flag) |=> !cap_flag); // R5
  AST_W1C_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && reg_wdata[1] && !ref_hit) |=> !ref_flag); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_flag && !cap_flag) |-> !irq); // R6
  AST_CAP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !cap_evt) |=> $stable(cap_q)); // R5
endmodule

// File: tb/gp_timer_tb.sv
`timescale 1ns/1ps
module gp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        tmr_in = 1'b0;
  logic        tmr_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_in(tmr_in),
    .tmr_out(tmr_out), .irq(irq)
  );

  // mode word: [15:8] prescale, [7:6] capture edge, [5] ref irq enable,
  // [4] toggle, [3] restart, [2:1] source, [0] enable
  function automatic logic [15:0] mk_mode(int pre, int cap, bit ie, bit tog,
                                          bit rst, int src, bit en);
    return {8'(pre), 2'(cap), ie, tog, rst, 2'(src), en};
  endfunction

  // expected counter after k enabled edges
  function automatic int exp_cnt(int src, int pre, int k, bit rst, int refv);
    int pulses = (src == 1) ? k : (k / 16);
    int t = pulses / (pre + 1);
    return rst ? (t % (refv + 1)) : (t % 65536);
  endfunction

  // reference arrivals within edges 1..n, bus source, restart mode
  function automatic int exp_hits(int pre, int refv, int n);
    int h = 0;
    for (int t = 1; t <= n; t++)
      if (t % (pre + 1) == 0 && ((t / (pre + 1)) % (refv + 1)) == refv) h++;
    return h;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    v = int'(reg_rdata);
  endtask

  task automatic pin_to(bit lvl);
    @(negedge clk);
    tmr_in = lvl;
    repeat (5) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int v, c1, c2, lows, tg, prev;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(3'd0, v); check("R9 mode reset", v, 0);
    rd(3'd3, v); check("R9 counter reset", v, 0);
    rd(3'd4, v); check("R9 event reset", v, 0);
    check("R9 out idle", int'(tmr_out), 1);
    check("R9 irq idle", int'(irq), 0);

    // R8 disabled: no counting, registers writable
    wr(3'd1, 16'd77);
    wr(3'd0, mk_mode(0, 0, 0, 0, 0, 1, 0));
    repeat (30) @(posedge clk);
    rd(3'd3, v); check("R8 held counter", v, 0);
    rd(3'd0, v); check("R8 mode writable", v, int'(mk_mode(0, 0, 0, 0, 0, 1, 0)));
    rd(3'd1, v); check("R8 ref writable", v, 77);

    // R1 full divide by 256
    wr(3'd0, mk_mode(255, 0, 0, 0, 0, 1, 1));
    repeat (600) @(posedge clk);
    rd(3'd3, v); check("R1 divide by 256", v, exp_cnt(1, 255, 600, 0, 0));

    // R2 stopped source
    wr(3'd0, 16'd0);
    wr(3'd0, mk_mode(0, 0, 0, 0, 0, 0, 1));
    repeat (40) @(posedge clk);
    rd(3'd3, v); check("R2 stopped source", v, 0);

    // R2 pin source, prescale 1: six falling edges -> 3
    wr(3'd0, 16'd0);
    wr(3'd0, mk_mode(1, 0, 0, 0, 0, 3, 1));
    for (int i = 0; i < 6; i++) begin
      pin_to(1'b1);
      pin_to(1'b0);
    end
    rd(3'd3, v); check("R2 pin falling edges", v, 3);

    // R1 R2 R3 random configurations
    for (int i = 0; i < 10; i++) begin
      int pre = $urandom % 4;
      int src = ($urandom % 2) ? 1 : 2;
      int k = 1 + $urandom % 300;
      bit rs = $urandom % 2;
      int rf = 5 + $urandom % 20;
      wr(3'd0, 16'd0);
      wr(3'd1, 16'(rf));
      wr(3'd0, mk_mode(pre, 0, 0, 0, rs, src, 1));
      repeat (k) @(posedge clk);
      rd(3'd3, v);
      check(rs ? "R3 random restart count" : "R1 R2 random count", v,
            exp_cnt(src, pre, k, rs, rf));
    end

    // R3 free-run passes the reference
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd4);
    wr(3'd0, mk_mode(0, 0, 0, 0, 0, 1, 1));
    repeat (20) @(posedge clk);
    rd(3'd3, v); check("R3 free-run past ref", v, 20);

    // R4 pulse mode, prescale 2, ref 3: one-clock lows
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd3);
    wr(3'd0, mk_mode(2, 0, 0, 0, 1, 1, 1));
    lows = 0;
    for (int t = 1; t <= 60; t++) begin
      @(negedge clk);
      if (tmr_out == 1'b0) lows++;
    end
    check("R4 pulse lows one clock each", lows, exp_hits(2, 3, 60));

    // R4 toggle mode, prescale 0, ref 3
    wr(3'd0, 16'd0);
    wr(3'd0, mk_mode(0, 0, 0, 1, 1, 1, 1));
    tg = 0; prev = 1;
    for (int t = 1; t <= 40; t++) begin
      @(negedge clk);
      if (int'(tmr_out) != prev) tg++;
      prev = int'(tmr_out);
    end
    check("R4 toggle count", tg, exp_hits(0, 3, 40));
    check("R4 toggle level", int'(tmr_out), (exp_hits(0, 3, 40) % 2 == 1) ? 0 : 1);

    // R6 R7 flags: freeze source, flag stays
    wr(3'd0, mk_mode(0, 0, 0, 1, 1, 0, 1));
    rd(3'd4, v); check("R7 ref flag set", v, 2);
    check("R6 irq masked", int'(irq), 0);
    wr(3'd0, mk_mode(0, 0, 1, 1, 1, 0, 1));
    @(negedge clk); check("R6 irq enabled", int'(irq), 1);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); check("R7 zero bit keeps flag", v, 2);
    wr(3'd4, 16'h0002);
    rd(3'd4, v); check("R7 w1c clears", v, 0);
    check("R6 irq drops", int'(irq), 0);

    // R5 capture rising
    wr(3'd0, 16'd0);
    wr(3'd1, 16'hFFFF);
    wr(3'd0, mk_mode(0, 1, 0, 0, 0, 1, 1));
    repeat (15) @(posedge clk);
    wr(3'd0, mk_mode(0, 1, 0, 0, 0, 0, 1));
    rd(3'd3, c1);
    pin_to(1'b1);
    rd(3'd2, v); check("R5 rising capture value", v, c1);
    rd(3'd4, v); check("R5 capture flag", v, 1);
    check("R6 capture irq", int'(irq), 1);
    wr(3'd4, 16'h0001);
    pin_to(1'b0);
    rd(3'd4, v); check("R5 falling ignored in rise mode", v, 0);

    // R5 falling mode, new count
    wr(3'd0, mk_mode(0, 2, 0, 0, 0, 1, 1));
    repeat (9) @(posedge clk);
    wr(3'd0, mk_mode(0, 2, 0, 0, 0, 0, 1));
    rd(3'd3, c2);
    pin_to(1'b1);
    rd(3'd4, v); check("R5 rising ignored in fall mode", v, 0);
    pin_to(1'b0);
    rd(3'd2, v); check("R5 falling capture value", v, c2);

    // R5 capture off: no change
    wr(3'd4, 16'h0001);
    wr(3'd0, mk_mode(0, 0, 0, 0, 0, 1, 1));
    repeat (5) @(posedge clk);
    wr(3'd0, mk_mode(0, 0, 0, 0, 0, 0, 1));
    pin_to(1'b1);
    pin_to(1'b0);
    rd(3'd2, v); check("R5 off keeps capture", v, c2);
    rd(3'd4, v); check("R5 off no flag", v, 0);

    // R8 disable clears capture
    wr(3'd0, 16'd0);
    rd(3'd2, v); check("R8 capture cleared", v, 0);

    done = 1'b1;
    finish_run();
  end
endmodule